// File: doc/BRIEF.md
# Stack Upper-Bound Checker

This block holds a single 32-bit upper limit for the stack in a special-purpose register. It watches every load and store issued by the pipeline. When the access uses the stack-pointer register as its base and its effective address lies above the limit, the block flags a stack underflow. The flag becomes an exception request only while the machine-status exception enable is set.

Software sets the limit through a small special-register port. The port has an address, a write strobe and write data, and the read data is returned combinationally. The limit register resets to all ones, so nothing traps until software lowers it.

The feature can be built out. Two things remove it: a build parameter, or a build with the memory-management unit present. Either one ties the limit at all ones, drops every write to it, and keeps the exception request low.

Top module: `stack_bound_chk`

## Requirements
- R1: After reset, a read at special-register address 0x0802 returns 0xFFFFFFFF.
- R2: A write at address 0x0802 sets the limit. The new value reads back and governs accesses from the next cycle on. An access in the same cycle as the write is still checked against the old limit.
- R3: stk_exc_o is high in the same cycle when all of the following hold: acc_valid_i and acc_ldst_i are high, base_idx_i equals 1, eff_addr_i is greater than the limit, and exc_en_i is high. It is low in every other cycle, so it is a one-cycle pulse per offending access.
- R4: An effective address equal to the limit does not raise the exception.
- R5: The address comparison is unsigned. With a limit of 0x7FFFFFFF, the address 0x80000000 raises the exception.
- R6: An access whose base index is anything other than 1 never raises the exception, whatever its address.
- R7: With exc_en_i low, no exception is raised even for an offending stack access.
- R8: With acc_valid_i low or acc_ldst_i low, no exception is raised.
- R9: A write at any address other than 0x0802 leaves the limit unchanged. A read at any other address returns 0.
- R10: When the feature is built out (USE_PROT = 0, or USE_MMU nonzero), writes are ignored, reads at 0x0802 return 0xFFFFFFFF, and stk_exc_o stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Memory access valid strobe |
| acc_ldst_i | input | 1 | Access is a load or store |
| base_idx_i | input | 5 | Base register index of the access |
| eff_addr_i | input | 32 | Effective address of the access |
| exc_en_i | input | 1 | Exception enable from the machine status register |
| spr_addr_i | input | 14 | Special-register address |
| spr_wr_i | input | 1 | Special-register write strobe |
| spr_wdata_i | input | 32 | Special-register write data |
| spr_rdata_o | output | 32 | Special-register read data |
| stk_exc_o | output | 1 | Stack-violation exception request |

## Verification
The case hardest to reach from the ports is a write to the limit in the same cycle as a stack access. In that cycle the access must be judged against the old limit, and from the next cycle against the new one. Random stimulus reaches this case often. Writes are issued alongside accesses, and addresses are biased to the limit minus one, the limit itself and the limit plus one, so the strict comparison is exercised around the moving bound. Directed cases add the unsigned sign-bit boundary and the two built-out variants.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int unsigned DEF_ADDR_W  = 32;
  localparam int unsigned DEF_IDX_W   = 5;
  localparam int unsigned DEF_SPR_AW  = 14;
  localparam int unsigned DEF_SP_IDX  = 1;
  localparam logic [13:0] DEF_SPR_SEL = 14'h0802;

  function automatic bit prot_active(input int unsigned use_prot, input int unsigned use_mmu);
    return (use_prot != 0) && (use_mmu == 0);
  endfunction
endpackage

// File: rtl/stk_bound_reg.sv
module stk_bound_reg #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned SPR_AW  = 14,
  parameter logic [SPR_AW-1:0] SPR_SEL = '0,
  parameter bit          ENABLED = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SPR_AW-1:0] spr_addr_i,
  input  logic              spr_wr_i,
  input  logic [ADDR_W-1:0] spr_wdata_i,
  output logic [ADDR_W-1:0] bound_o,
  output logic [ADDR_W-1:0] rdata_o
);
  logic sel;
  logic wr_en;
  logic [ADDR_W-1:0] bound_q;

  assign sel   = (spr_addr_i == SPR_SEL);
  assign wr_en = ENABLED && sel && spr_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    bound_q <= '1;
    else if (wr_en) bound_q <= spr_wdata_i;
  end

  // built-out variant reads as the reset value
  generate
    if (ENABLED) begin : g_live
      assign bound_o = bound_q;
    end else begin : g_tied
      assign bound_o = '1;
    end
  endgenerate

  assign rdata_o = sel ? bound_o : '0;
endmodule

// File: rtl/stk_acc_qual.sv
module stk_acc_qual #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned SP_IDX = 1
) (
  input  logic              acc_valid_i,
  input  logic              acc_ldst_i,
  input  logic [IDX_W-1:0]  base_idx_i,
  input  logic [ADDR_W-1:0] eff_addr_i,
  input  logic [ADDR_W-1:0] bound_i,
  output logic              hit_o
);
  localparam logic [IDX_W-1:0] SP = IDX_W'(SP_IDX);

  logic is_stack;
  logic above;

  assign is_stack = acc_valid_i && acc_ldst_i && (base_idx_i == SP);
  assign above    = eff_addr_i > bound_i; // unsigned, strict
  assign hit_o    = is_stack && above;
endmodule

// File: rtl/stack_bound_chk.sv
module stack_bound_chk
  import stk_pkg::*;
#(
  parameter int unsigned ADDR_W   = DEF_ADDR_W,
  parameter int unsigned IDX_W    = DEF_IDX_W,
  parameter int unsigned SP_IDX   = DEF_SP_IDX,
  parameter int unsigned SPR_AW   = DEF_SPR_AW,
  parameter logic [SPR_AW-1:0] SPR_SEL = SPR_AW'(DEF_SPR_SEL),
  parameter int unsigned USE_PROT = 1,
  parameter int unsigned USE_MMU  = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic              acc_ldst_i,
  input  logic [IDX_W-1:0]  base_idx_i,
  input  logic [ADDR_W-1:0] eff_addr_i,
  input  logic              exc_en_i,
  input  logic [SPR_AW-1:0] spr_addr_i,
  input  logic              spr_wr_i,
  input  logic [ADDR_W-1:0] spr_wdata_i,
  output logic [ADDR_W-1:0] spr_rdata_o,
  output logic              stk_exc_o
);
  localparam bit PROT_ON = prot_active(USE_PROT, USE_MMU);

  logic [ADDR_W-1:0] bound;
  logic              hit;

  stk_bound_reg #(
    .ADDR_W (ADDR_W),
    .SPR_AW (SPR_AW),
    .SPR_SEL(SPR_SEL),
    .ENABLED(PROT_ON)
  ) u_bound (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .spr_addr_i (spr_addr_i),
    .spr_wr_i   (spr_wr_i),
    .spr_wdata_i(spr_wdata_i),
    .bound_o    (bound),
    .rdata_o    (spr_rdata_o)
  );

  stk_acc_qual #(
    .ADDR_W(ADDR_W),
    .IDX_W (IDX_W),
    .SP_IDX(SP_IDX)
  ) u_qual (
    .acc_valid_i(acc_valid_i),
    .acc_ldst_i (acc_ldst_i),
    .base_idx_i (base_idx_i),
    .eff_addr_i (eff_addr_i),
    .bound_i    (bound),
    .hit_o      (hit)
  );

  assign stk_exc_o = PROT_ON && exc_en_i && hit;
endmodule

// File: rtl/stack_bound_chk_sva.sv
module stack_bound_chk_sva #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned SP_IDX = 1,
  parameter int unsigned SPR_AW = 14,
  parameter logic [SPR_AW-1:0] SPR_SEL = '0,
  parameter bit          PROT_ON = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              acc_valid_i,
  input logic              acc_ldst_i,
  input logic [IDX_W-1:0]  base_idx_i,
  input logic [ADDR_W-1:0] eff_addr_i,
  input logic              exc_en_i,
  input logic [SPR_AW-1:0] spr_addr_i,
  input logic              spr_wr_i,
  input logic [ADDR_W-1:0] spr_wdata_i,
  input logic [ADDR_W-1:0] bound_i,
  input logic              stk_exc_o
);
  // R3, R6, R7, R8
  a_r3_exc_qualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_exc_o |-> (acc_valid_i && acc_ldst_i && exc_en_i && base_idx_i == IDX_W'(SP_IDX)));

  // R4, R5
  a_r4_strictly_above: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_exc_o |-> (eff_addr_i > bound_i));

  a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (PROT_ON && spr_wr_i && spr_addr_i == SPR_SEL) |=> (bound_i == $past(spr_wdata_i)));

  a_r9_other_addr_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spr_addr_i != SPR_SEL) |=> $stable(bound_i));

  a_r10_off_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!PROT_ON && acc_valid_i) |-> (!stk_exc_o && bound_i == '1));
endmodule

bind stack_bound_chk stack_bound_chk_sva #(
  .ADDR_W (ADDR_W),
  .IDX_W  (IDX_W),
  .SP_IDX (SP_IDX),
  .SPR_AW (SPR_AW),
  .SPR_SEL(SPR_SEL),
  .PROT_ON(PROT_ON)
) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .acc_valid_i(acc_valid_i),
  .acc_ldst_i (acc_ldst_i),
  .base_idx_i (base_idx_i),
  .eff_addr_i (eff_addr_i),
  .exc_en_i   (exc_en_i),
  .spr_addr_i (spr_addr_i),
  .spr_wr_i   (spr_wr_i),
  .spr_wdata_i(spr_wdata_i),
  .bound_i    (bound),
  .stk_exc_o  (stk_exc_o)
);

// File: tb/sim_stack_bound_chk.sv
module sim_stack_bound_chk;
  localparam logic [13:0] SEL = 14'h0802;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, ldst = 1'b0, en = 1'b0, wr = 1'b0;
  logic [4:0]  base = '0;
  logic [31:0] addr = '0, wdata = '0;
  logic [13:0] saddr = '0;
  logic [31:0] rd0, rd1, rd2;
  logic        exc0, exc1, exc2;

  int checks = 0;
  int errors = 0;
  logic [31:0] bound_m = 32'hFFFF_FFFF;

  always #2 clk = ~clk;

  stack_bound_chk u0 (.clk_i(clk), .rst_ni(rst_n), .acc_valid_i(valid), .acc_ldst_i(ldst),
    .base_idx_i(base), .eff_addr_i(addr), .exc_en_i(en), .spr_addr_i(saddr), .spr_wr_i(wr),
    .spr_wdata_i(wdata), .spr_rdata_o(rd0), .stk_exc_o(exc0));
  stack_bound_chk #(.USE_MMU(1)) u1 (.clk_i(clk), .rst_ni(rst_n), .acc_valid_i(valid),
    .acc_ldst_i(ldst), .base_idx_i(base), .eff_addr_i(addr), .exc_en_i(en), .spr_addr_i(saddr),
    .spr_wr_i(wr), .spr_wdata_i(wdata), .spr_rdata_o(rd1), .stk_exc_o(exc1));
  stack_bound_chk #(.USE_PROT(0)) u2 (.clk_i(clk), .rst_ni(rst_n), .acc_valid_i(valid),
    .acc_ldst_i(ldst), .base_idx_i(base), .eff_addr_i(addr), .exc_en_i(en), .spr_addr_i(saddr),
    .spr_wr_i(wr), .spr_wdata_i(wdata), .spr_rdata_o(rd2), .stk_exc_o(exc2));

  function automatic logic exp_exc(logic v, logic l, logic [4:0] b, logic [31:0] a, logic e,
                                   logic [31:0] bnd);
    return v && l && e && (b == 5'd1) && (a > bnd);
  endfunction

  function automatic logic [31:0] exp_rd(logic [13:0] sa, logic [31:0] bnd);
    return (sa == SEL) ? bnd : 32'h0;
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive after negedge, check combinational outputs, then let posedge commit
  task automatic step(logic v, logic l, logic [4:0] b, logic [31:0] a, logic e,
                      logic w, logic [13:0] sa, logic [31:0] wd, string req);
    @(negedge clk);
    valid = v; ldst = l; base = b; addr = a; en = e; wr = w; saddr = sa; wdata = wd;
    #1;
    check(req, {31'b0, exc0}, {31'b0, exp_exc(v, l, b, a, e, bound_m)});
    check(req, rd0, exp_rd(sa, bound_m));
    check("R10", {31'b0, exc1}, 32'h0);
    check("R10", {31'b0, exc2}, 32'h0);
    check("R10", rd1, exp_rd(sa, 32'hFFFF_FFFF));
    check("R10", rd2, exp_rd(sa, 32'hFFFF_FFFF));
    @(posedge clk);
    if (w && sa == SEL) bound_m = wd;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5eed));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset value
    step(0, 0, 0, 0, 0, 0, SEL, 0, "R1");
    // R9 write elsewhere, read elsewhere
    step(0, 0, 0, 0, 0, 1, 14'h0801, 32'h10, "R9");
    step(0, 0, 0, 0, 0, 0, SEL, 0, "R9");
    // R2 set bound; same-cycle access uses old bound
    step(1, 1, 1, 32'h2000, 1, 1, SEL, 32'h1000, "R2");
    step(0, 0, 0, 0, 0, 0, SEL, 0, "R2");
    step(1, 1, 1, 32'h1000, 1, 0, 0, 0, "R4");
    step(1, 1, 1, 32'h1001, 1, 0, 0, 0, "R3");
    step(1, 1, 2, 32'hFFFF_0000, 1, 0, 0, 0, "R6");
    step(1, 1, 1, 32'h1001, 0, 0, 0, 0, "R7");
    step(0, 1, 1, 32'h1001, 1, 0, 0, 0, "R8");
    step(1, 0, 1, 32'h1001, 1, 0, 0, 0, "R8");
    // R5 unsigned at sign boundary
    step(0, 0, 0, 0, 0, 1, SEL, 32'h7FFF_FFFF, "R2");
    step(1, 1, 1, 32'h8000_0000, 1, 0, 0, 0, "R5");
    step(1, 1, 1, 32'h7FFF_FFFF, 1, 0, 0, 0, "R4");

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a;
      logic [4:0]  b;
      logic [13:0] sa;
      int unsigned pick = $urandom_range(0, 5);
      case (pick)
        0: a = bound_m - 1;
        1: a = bound_m;
        2: a = bound_m + 1;
        default: a = $urandom;
      endcase
      b  = ($urandom_range(0, 3) != 0) ? 5'd1 : 5'($urandom);
      sa = ($urandom_range(0, 2) != 0) ? SEL : 14'($urandom);
      step($urandom_range(0, 5) != 0, $urandom_range(0, 5) != 0, b, a,
           $urandom_range(0, 4) != 0, $urandom_range(0, 6) == 0, sa, $urandom, "R3");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule